// File: doc/BRIEF.md
# Video Frame Capture to SRAM

The block takes an 8-bit parallel component video stream with in-band timing reference codes and copies one frame of active picture into an external asynchronous SRAM. All logic runs on the pixel clock delivered with the stream. After a start request it ignores the stream until it sees the beginning of a frame. It then stores every active-video byte at consecutive SRAM addresses from zero until either a set number of complete lines has been stored or the address space is full.

When capture ends the block raises a done flag and stops driving the SRAM bus, so another agent can take the memory over. A further start request clears the flag and arms a new capture. Horizontal position is recovered from the start-of-active-video codes rather than from a free-running counter, so a glitch in the stream realigns on the next code.

Top module: `vid_frame_capture`

## Requirements
- R1: While rst_ni is low and after its release, sram_we_no is 1, done_o is 0, sram_drive_o is 0 and sram_addr_o is 0.
- R2: start_i is acted on only while the block is idle or done; a start pulse during waiting or capturing has no effect on the stored data or the addresses.
- R3: A timing code is the byte run FF, 00, 00, XY; in XY bit 6 is the field flag, bit 5 the vertical-blanking flag and bit 4 the code type, 0 for start of active video (SAV) and 1 for end of active video (EAV).
- R4: After a start, nothing is written until an SAV with vertical flag 0 and field flag 0 arrives after at least one SAV with vertical flag 1 has been seen since the start; the first active byte of that line goes to address 0.
- R5: Each accepted SAV is followed by ACTIVE_LEN stored bytes, the bytes immediately after the XY byte, at consecutive addresses; blanking bytes and the bytes of the codes themselves are not stored.
- R6: While capturing, an SAV with vertical flag 1 starts no line; the field flag is not looked at.
- R7: Each stored byte produces exactly one clock with sram_we_no low, during which sram_addr_o and sram_data_o hold that byte's address and value and sram_drive_o is 1; the write cycle is the clock after the byte was sampled.
- R8: After ACTIVE_LINES complete lines the capture ends: done_o rises in the clock right after the last write clock, and from then on sram_we_no is 1 and sram_drive_o is 0.
- R9: A write to the highest address (all ADDR_W bits set) ends the capture in the same way, even in the middle of a line.
- R10: An SAV with vertical flag 0 that arrives while a line is still being stored restarts the line count at that code; the bytes already taken, including the FF, 00, 00, XY of the interrupting code, stay stored and the truncated line does not count toward ACTIVE_LINES.
- R11: Once done, no byte is written and done_o stays 1 until a start; that start clears done_o in the next clock, raises sram_drive_o one clock later and the new capture begins again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock from the video source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a new capture (idle or done only) |
| vid_i | input | DATA_W | Parallel video byte stream |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_data_o | output | DATA_W | SRAM write data |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_drive_o | output | 1 | High while the block owns the SRAM bus |
| done_o | output | 1 | Frame stored, bus released |

## Verification
The line-count limit and the address wrap can both fire on the same stored byte; a second instance with a 16-location address space and a two-line limit is fed the same eight-byte lines, so its sixteenth byte completes the second line and fills the memory at once, and the bench judges that exactly sixteen writes happen with done rising one clock after the last. In the second frame the same instance hits the wrap alone in mid-line after a resync, while the main instance keeps capturing. A resync code landing inside a line that is being stored is also provoked, and the stored byte run is compared against the order the requirements predict.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SAVE,
    ST_DONE
  } cap_state_e;

  // decoded timing reference code
  typedef struct packed {
    logic valid;
    logic fld;
    logic vblk;
    logic eav;
  } trs_t;

endpackage

// File: rtl/vcap_trs_detect.sv
module vcap_trs_detect
  import vcap_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] vid_i,
  output trs_t              trs_o
);

  localparam int unsigned HIST   = 3;
  localparam int unsigned FLD_B  = DATA_W - 2;
  localparam int unsigned VBLK_B = DATA_W - 3;
  localparam int unsigned EAV_B  = DATA_W - 4;

  logic [DATA_W-1:0] hist_q [HIST];
  logic              preamble;
  trs_t              trs_q;

  assign preamble = (hist_q[2] == '1) && (hist_q[1] == '0) && (hist_q[0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
      trs_q <= '0;
    end else begin
      hist_q[0] <= vid_i;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
      trs_q.valid <= preamble;
      trs_q.fld   <= vid_i[FLD_B];
      trs_q.vblk  <= vid_i[VBLK_B];
      trs_q.eav   <= vid_i[EAV_B];
    end
  end

  assign trs_o = trs_q;

  // R3
  trs_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_q.valid |=> !trs_q.valid);

endmodule

// File: rtl/vcap_line_track.sv
module vcap_line_track #(
  parameter int unsigned ACTIVE_LEN = 1440
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic go_i,
  output logic take_o,
  output logic last_o
);

  localparam int unsigned CNT_W = $clog2(ACTIVE_LEN + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  // an SAV always realigns, even mid-line
  assign cnt_nx = go_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign take_o = en_i & (go_i | active_q);
  assign last_o = take_o & (cnt_nx == CNT_W'(ACTIVE_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (take_o) begin
      active_q <= ~last_o;
      cnt_q    <= cnt_nx;
    end
  end

  // R5
  pix_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0) && (cnt_q < CNT_W'(ACTIVE_LEN)));

endmodule

// File: rtl/vcap_sram_wr.sv
module vcap_sram_wr #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              own_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              we_no,
  output logic              drive_o
);

  logic [ADDR_W-1:0] cnt_q, addr_q;
  logic [DATA_W-1:0] data_q;
  logic              we_n_q, drive_q;

  assign last_o = wr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      we_n_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      drive_q <= own_i;
      we_n_q  <= ~wr_i;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (wr_i) begin
        cnt_q  <= cnt_q + ADDR_W'(1);
        addr_q <= cnt_q;
        data_q <= data_i;
      end
    end
  end

  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign we_no   = we_n_q;
  assign drive_o = drive_q;

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_q && $past(!we_n_q)) |-> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R7
  write_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> drive_q);

endmodule

// File: rtl/vid_frame_capture.sv
module vid_frame_capture
  import vcap_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned ACTIVE_LEN   = 1440,
  parameter int unsigned ACTIVE_LINES = 487
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] vid_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_data_o,
  output logic              sram_we_no,
  output logic              sram_drive_o,
  output logic              done_o
);

  localparam int unsigned LINE_W = $clog2(ACTIVE_LINES + 1);

  trs_t              trs;
  cap_state_e        state_q, state_d;
  logic              vblk_seen_q, done_q;
  logic [LINE_W-1:0] line_cnt_q;
  logic              sav, line_go, capturing, arm;
  logic              take, line_last, wr_last, last_line, stop;

  vcap_trs_detect #(.DATA_W(DATA_W)) i_trs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vid_i (vid_i),
    .trs_o (trs)
  );

  assign sav       = trs.valid & ~trs.eav;
  assign capturing = (state_q == ST_WAIT) || (state_q == ST_SAVE);
  assign arm       = start_i & ((state_q == ST_IDLE) || (state_q == ST_DONE));

  always_comb begin
    unique case (state_q)
      ST_WAIT: line_go = sav & ~trs.vblk & ~trs.fld & vblk_seen_q;
      ST_SAVE: line_go = sav & ~trs.vblk;
      default: line_go = 1'b0;
    endcase
  end

  vcap_line_track #(.ACTIVE_LEN(ACTIVE_LEN)) i_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (capturing),
    .go_i  (line_go),
    .take_o(take),
    .last_o(line_last)
  );

  vcap_sram_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm),
    .own_i  (capturing),
    .wr_i   (take),
    .data_i (vid_i),
    .last_o (wr_last),
    .addr_o (sram_addr_o),
    .data_o (sram_data_o),
    .we_no  (sram_we_no),
    .drive_o(sram_drive_o)
  );

  assign last_line = line_last && (line_cnt_q == LINE_W'(ACTIVE_LINES - 1));
  assign stop      = wr_last | last_line;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_WAIT;
      ST_WAIT: if (stop) state_d = ST_DONE;
               else if (line_go) state_d = ST_SAVE;
      ST_SAVE: if (stop) state_d = ST_DONE;
      ST_DONE: if (start_i) state_d = ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vblk_seen_q <= 1'b0;
      line_cnt_q  <= '0;
      done_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_DONE) && (state_d == ST_DONE);
      if (arm) begin
        vblk_seen_q <= 1'b0;
        line_cnt_q  <= '0;
      end else begin
        if (state_q == ST_WAIT && sav && trs.vblk) vblk_seen_q <= 1'b1;
        if (line_last) line_cnt_q <= line_cnt_q + LINE_W'(1);
      end
    end
  end

  assign done_o = done_q;

  // R8
  done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(sram_we_no) == 1'b0);

  // R8
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sram_we_no && !sram_drive_o);

  // R4
  no_early_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> sram_we_no);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && $past(state_q) == ST_DONE) |-> sram_we_no);

endmodule

// File: tb/test_vid_frame_capture.sv
module test_vid_frame_capture;

  localparam int unsigned DW  = 8;
  localparam int unsigned AW  = 20;
  localparam int unsigned AWW = 4;
  localparam int unsigned AL  = 8;
  localparam int unsigned NL  = 3;
  localparam int unsigned NLW = 2;
  localparam int unsigned BL  = 6;
  localparam int unsigned WRAP_N = 1 << AWW;

  // row: [7] start pulse before line, [6] vblank, [5] field, [4] stored by main, [3:0] resync cut
  localparam int N1 = 11;
  localparam logic [7:0] ROWS1 [N1] = '{
    8'h00, 8'h80, 8'h40, 8'h60, 8'h10, 8'h40, 8'hB0, 8'h10, 8'h00, 8'h40, 8'h00 };
  localparam int N2 = 5;
  localparam logic [7:0] ROWS2 [N2] = '{
    8'h40, 8'h13, 8'h10, 8'h10, 8'h00 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] vid = 8'h10;

  logic [AW-1:0]  m_addr;
  logic [DW-1:0]  m_data;
  logic           m_we_n, m_drive, m_done;
  logic [AWW-1:0] w_addr;
  logic [DW-1:0]  w_data;
  logic           w_we_n, w_drive, w_done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [AW-1:0]  got_m_addr [$];
  logic [DW-1:0]  got_m_data [$];
  logic [AWW-1:0] got_w_addr [$];
  logic [DW-1:0]  got_w_data [$];
  logic [DW-1:0]  exp_q [$];
  int m_last_wr, w_last_wr, m_done_cyc, w_done_cyc, undriven_wr;
  logic m_done_d, w_done_d;

  always #2 clk = ~clk;

  vid_frame_capture #(.DATA_W(DW), .ADDR_W(AW), .ACTIVE_LEN(AL), .ACTIVE_LINES(NL)) i_vid_frame_capture (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vid_i(vid),
    .sram_addr_o(m_addr), .sram_data_o(m_data), .sram_we_no(m_we_n),
    .sram_drive_o(m_drive), .done_o(m_done));

  vid_frame_capture #(.DATA_W(DW), .ADDR_W(AWW), .ACTIVE_LEN(AL), .ACTIVE_LINES(NLW)) i_vid_frame_capture_wrap (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vid_i(vid),
    .sram_addr_o(w_addr), .sram_data_o(w_data), .sram_we_no(w_we_n),
    .sram_drive_o(w_drive), .done_o(w_done));

  // monitor, away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (!m_we_n) begin
        got_m_addr.push_back(m_addr);
        got_m_data.push_back(m_data);
        m_last_wr = cyc;
        if (!m_drive) undriven_wr++;
      end
      if (!w_we_n) begin
        got_w_addr.push_back(w_addr);
        got_w_data.push_back(w_data);
        w_last_wr = cyc;
        if (!w_drive) undriven_wr++;
      end
      if (m_done && !m_done_d) m_done_cyc = cyc;
      if (w_done && !w_done_d) w_done_cyc = cyc;
      m_done_d = m_done;
      w_done_d = w_done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [DW-1:0] b);
    @(negedge clk);
    vid = b;
  endtask

  function automatic logic [DW-1:0] xy(input logic v, input logic f, input logic e);
    return {1'b1, f, v, e, 4'b0000};
  endfunction

  function automatic logic [DW-1:0] pix(input int id, input int i);
    return DW'(32 + id * 8 + i);
  endfunction

  task automatic put_code(input logic v, input logic f, input logic e, input logic st);
    logic [DW-1:0] seq [4];
    seq = '{8'hFF, 8'h00, 8'h00, xy(v, f, e)};
    foreach (seq[k]) begin
      put(seq[k]);
      if (st) exp_q.push_back(seq[k]);
    end
  endtask

  task automatic send_line(input logic v, input logic f, input int id, input int cut, input logic st);
    for (int i = 0; i < BL; i++) put(i[0] ? 8'h10 : 8'h80);
    put_code(v, f, 1'b0, 1'b0);
    if (cut > 0) begin
      for (int i = 0; i < cut; i++) begin
        put(pix(id, i));
        if (st) exp_q.push_back(pix(id, i));
      end
      put_code(v, f, 1'b0, st);
    end
    for (int i = 0; i < AL; i++) begin
      put(pix(id, i));
      if (st) exp_q.push_back(pix(id, i));
    end
    put_code(v, f, 1'b1, 1'b0);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_row(input logic [7:0] row, input int id);
    if (row[7]) pulse_start();
    send_line(row[6], row[5], id, int'(row[3:0]), row[4]);
  endtask

  task automatic clear_logs();
    got_m_addr.delete(); got_m_data.delete();
    got_w_addr.delete(); got_w_data.delete();
    exp_q.delete();
  endtask

  task automatic judge(input string tag);
    int bad_d, bad_a, bad_w;
    bad_d = 0; bad_a = 0; bad_w = 0;
    chk(got_m_data.size() == exp_q.size(), "R7", {tag, " main write count"}, got_m_data.size(), exp_q.size());
    foreach (got_m_data[k]) begin
      if (k < exp_q.size() && got_m_data[k] != exp_q[k]) bad_d++;
      if (int'(got_m_addr[k]) != k) bad_a++;
    end
    chk(bad_d == 0, "R5 R6 R10", {tag, " main data mismatches"}, bad_d, 0);
    chk(bad_a == 0, "R5", {tag, " main address mismatches"}, bad_a, 0);
    if (got_m_data.size() > 0) chk(got_m_data[0] == exp_q[0], "R3 R4", {tag, " first stored byte"}, got_m_data[0], exp_q[0]);
    chk(got_w_data.size() == WRAP_N, "R9", {tag, " wrap write count"}, got_w_data.size(), WRAP_N);
    foreach (got_w_data[k]) begin
      if (k >= exp_q.size() || got_w_data[k] != exp_q[k] || int'(got_w_addr[k]) != k) bad_w++;
    end
    chk(bad_w == 0, "R9", {tag, " wrap data/address mismatches"}, bad_w, 0);
    chk(m_done && m_we_n && !m_drive, "R8", {tag, " main done with bus released"}, {m_done, m_we_n, m_drive}, 3'b110);
    chk(w_done && w_we_n && !w_drive, "R9", {tag, " wrap done with bus released"}, {w_done, w_we_n, w_drive}, 3'b110);
    chk(m_done_cyc == m_last_wr + 1, "R8", {tag, " main done timing"}, m_done_cyc, m_last_wr + 1);
    chk(w_done_cyc == w_last_wr + 1, "R9", {tag, " wrap done timing"}, w_done_cyc, w_last_wr + 1);
    chk(undriven_wr == 0, "R7", {tag, " writes without bus drive"}, undriven_wr, 0);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_last_wr = -10; w_last_wr = -10; m_done_cyc = -1; w_done_cyc = -1; undriven_wr = 0;
    m_done_d = 1'b0; w_done_d = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values while held
    chk(m_we_n && !m_done && !m_drive && m_addr == '0, "R1", "main outputs in reset",
        {m_we_n, m_done, m_drive}, 3'b100);
    chk(w_we_n && !w_done && !w_drive && w_addr == '0, "R1", "wrap outputs in reset",
        {w_we_n, w_done, w_drive}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(m_we_n && !m_done && !m_drive, "R1", "main outputs after release",
        {m_we_n, m_done, m_drive}, 3'b100);

    // frame 1: table walk; row 0 before start, row 6 carries an ignored start (R2)
    for (int r = 0; r < N1; r++) begin
      run_row(ROWS1[r], r);
      if (r == 0) chk(got_m_data.size() == 0, "R2", "no write before start", got_m_data.size(), 0);
      if (r == 6) chk(w_done == 1'b1 && m_done == 1'b0, "R9", "wrap and line limit coincide, main still busy",
                      {w_done, m_done}, 2'b10);
    end
    repeat (4) put(8'h10);
    judge("frame1");
    chk(m_done == 1'b1, "R11", "done holds after further lines", m_done, 1);

    // frame 2: restart, resync in the first stored line, wrap mid-line
    clear_logs();
    pulse_start();
    chk(m_done == 1'b0, "R11", "done cleared by start", m_done, 0);
    @(negedge clk);
    chk(m_drive == 1'b1, "R11", "bus owned again after start", m_drive, 1);
    for (int r = 0; r < N2; r++) run_row(ROWS2[r], 20 + r);
    repeat (4) put(8'h10);
    judge("frame2");
    if (got_m_addr.size() > 0) chk(got_m_addr[0] == '0, "R11", "restart at address zero", int'(got_m_addr[0]), 0);
    chk(got_m_data.size() == 7 + NL * AL, "R10", "truncated line not counted", got_m_data.size(), 7 + NL * AL);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule